// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the routing configuration for a bank of interrupt pins behind a two-location bus aperture. Software first writes a window index into the select location (offset 0x00) and then reads or writes the indexed register through the data location (offset 0x10). Three small registers sit behind the window: an identification register, a constant version word and a read-only arbitration copy of the identification. After them comes one 64-bit redirection entry per pin. Each entry is split into a low and a high 32-bit half at two neighbouring window indices.

A delivery engine beside the block sees every entry in full on a flat side port. It owns two status bits in each low half, remote IRR and delivery status, which it sets and clears through per-entry strobes. Bus writes can never change those two bits. Each write to an entry raises a one-cycle per-entry update pulse, which tells the engine to reload that entry.

A small bus-control state machine handles reads. It has two states. BUS_IDLE is the resting state. BUS_RESP is the single cycle in which registered read data is presented with `bus_rvalid` high. Transition ACCEPT_READ goes from either state to BUS_RESP when a read hits offset 0x00 or 0x10 in that cycle. Transition RETIRE goes to BUS_IDLE whenever no such read is present. Writes do not change the state.

Top module: `irq_redir_regfile`

## Requirements
- R1: The select register (offset 0x00) is 32 bits wide, resets to 0 and reads back what was written. The window index is its bits 7:0. A write to any offset other than 0x00 or 0x10 changes nothing. A read of such an offset leaves `bus_rdata` unchanged and does not raise `bus_rvalid`.
- R2: A read of offset 0x00 or 0x10 presents its data on `bus_rdata` with `bus_rvalid` high for exactly the one cycle after the read request.
- R3: Window index 0x00 is the ID register. It resets to 0. A write keeps data bits 27:24. A read returns those four bits in bits 27:24 with every other bit zero.
- R4: Window index 0x01 reads as 0x00170011. A write of zero there raises no error. A nonzero write raises `bus_err` for one cycle and has no other effect.
- R5: Window index 0x02 reads the same value as the ID register. A write to it changes nothing and raises `bus_err`.
- R6: Entry n is reached at window index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32. A write changes only the addressed entry.
- R7: A write to a low half replaces the bits under mask 0xFFFF_AFFF. Bit 12 (delivery status) and bit 14 (remote IRR) keep their values.
- R8: A write to a high half replaces bits 63:32 completely and leaves bits 31:0 unchanged.
- R9: After reset every entry reads 0x0000_0000_0001_0000, which is bit 16 (mask) set. `ent_data[64n+63:64n]` always shows entry n. Its fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15, mask 16, destination 63:56.
- R10: A window index that is neither 0x00–0x02 nor an entry half is invalid. A read of it returns 0. A read or write of it raises `bus_err` for one cycle, and a write changes nothing.
- R11: `rirr_set[n]`/`rirr_clr[n]` set or clear bit 14 of entry n on the next edge. `dstat_set[n]`/`dstat_clr[n]` do the same for bit 12. A set wins over a clear. In a cycle where a side strobe and a bus write to the same low half coincide, the strobe decides those two bits.
- R12: A write to either half of entry n makes `ent_upd[n]`, and only that bit, high for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_addr | input | AW (8) | Bus offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | One-cycle error pulse |
| rirr_set | input | N_ENT (24) | Per-entry remote IRR set |
| rirr_clr | input | N_ENT (24) | Per-entry remote IRR clear |
| dstat_set | input | N_ENT (24) | Per-entry delivery status set |
| dstat_clr | input | N_ENT (24) | Per-entry delivery status clear |
| ent_data | output | 64*N_ENT | All entries, entry n at bits 64n+63:64n |
| ent_upd | output | N_ENT (24) | Per-entry write pulse |

## Verification
The checker watches several rules on every cycle. `bus_rvalid` must always follow a read. At most one update bit may be high at a time. A nonzero version write must always produce an error. The select register must load the written data. Bus writes must never move either status bit of an entry when no strobe is active, a high-half write must leave the low half alone, and a remote IRR set strobe must take effect. Other behaviours can only be shown by the bench's scenarios: the exact read values, the reset contents, set-over-clear priority, the strobe winning against a simultaneous bus write, and the "no change" outcomes of bad offsets and invalid indices.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ENT_W  = 64;

    localparam logic [31:0] LO_WR_MASK   = 32'hFFFF_AFFF;
    localparam logic [31:0] LO_RESET     = 32'h0001_0000;
    localparam logic [31:0] HI_RESET     = 32'h0000_0000;
    localparam logic [31:0] VERSION_WORD = 32'h0017_0011;

    localparam int unsigned BIT_DSTAT = 12;
    localparam int unsigned BIT_RIRR  = 14;
    localparam int unsigned ID_LSB    = 24;

    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam logic [7:0] IDX_TBL_BASE = 8'h10;

    typedef enum logic [2:0] {
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_LO,
        WK_HI,
        WK_BAD
    } win_kind_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int unsigned N_ENT = 24,
    parameter int unsigned EIW   = 5
) (
    input  logic [7:0]     win_idx,
    output win_kind_e      kind,
    output logic [EIW-1:0] ent_idx
);

    localparam int unsigned LAST_IDX = 16 + 2 * N_ENT - 1;

    logic [7:0] rel;

    always_comb begin
        rel     = win_idx - IDX_TBL_BASE;
        ent_idx = rel[EIW:1];
        if (win_idx == IDX_ID) begin
            kind = WK_ID;
        end else if (win_idx == IDX_VER) begin
            kind = WK_VER;
        end else if (win_idx == IDX_ARB) begin
            kind = WK_ARB;
        end else if (win_idx >= IDX_TBL_BASE && win_idx <= 8'(LAST_IDX)) begin
            kind = win_idx[0] ? WK_HI : WK_LO;
        end else begin
            kind = WK_BAD;
        end
    end

endmodule

// File: rtl/irq_rf_entry.sv
module irq_rf_entry
    import irq_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dstat_set,
    input  logic        dstat_clr,
    output logic [63:0] q,
    output logic        upd
);

    logic [31:0] lo_q, hi_q, lo_d, hi_d;

    always_comb begin
        lo_d = wr_lo ? ((wdata & LO_WR_MASK) | (lo_q & ~LO_WR_MASK)) : lo_q;
        hi_d = wr_hi ? wdata : hi_q;
        // side-band strobes own the status bits; set beats clear
        if (dstat_set) begin
            lo_d[BIT_DSTAT] = 1'b1;
        end else if (dstat_clr) begin
            lo_d[BIT_DSTAT] = 1'b0;
        end
        if (rirr_set) begin
            lo_d[BIT_RIRR] = 1'b1;
        end else if (rirr_clr) begin
            lo_d[BIT_RIRR] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RESET;
            hi_q <= HI_RESET;
            upd  <= 1'b0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            upd  <= wr_lo | wr_hi;
        end
    end

    assign q = {hi_q, lo_q};

endmodule

// File: rtl/irq_rf_busctl.sv
module irq_rf_busctl
    import irq_rf_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    input  win_kind_e     kind,
    input  logic [31:0]   tbl_word,
    output logic [31:0]   sel_q,
    output logic          tbl_wr_lo,
    output logic          tbl_wr_hi,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    output logic          bus_err
);

    localparam logic [AW-1:0] OFF_SEL = AW'(8'h00);
    localparam logic [AW-1:0] OFF_WIN = AW'(8'h10);

    bus_state_e  state_q, state_d;
    logic [3:0]  id_q;
    logic        hit_sel, hit_win, win_wr, rd_take, err_d;
    logic [31:0] rd_val, id_word;

    always_comb begin
        hit_sel   = (bus_addr == OFF_SEL);
        hit_win   = (bus_addr == OFF_WIN);
        win_wr    = bus_wr && hit_win;
        rd_take   = bus_rd && (hit_sel || hit_win);
        tbl_wr_lo = win_wr && (kind == WK_LO);
        tbl_wr_hi = win_wr && (kind == WK_HI);
        id_word   = {4'b0, id_q, 24'b0};
        err_d     = (win_wr && ((kind == WK_VER && bus_wdata != 32'h0) ||
                                kind == WK_ARB || kind == WK_BAD)) ||
                    (bus_rd && hit_win && kind == WK_BAD);
    end

    always_comb begin
        if (hit_sel) begin
            rd_val = sel_q;
        end else begin
            unique case (kind)
                WK_ID, WK_ARB: rd_val = id_word;
                WK_VER:        rd_val = VERSION_WORD;
                WK_LO, WK_HI:  rd_val = tbl_word;
                default:       rd_val = 32'h0;
            endcase
        end
    end

    // next-state: ACCEPT_READ / RETIRE
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_take ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_take ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 32'h0;
            id_q      <= 4'h0;
            bus_rdata <= 32'h0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= err_d;
            if (bus_wr && hit_sel) begin
                sel_q <= bus_wdata;
            end
            if (win_wr && kind == WK_ID) begin
                id_q <= bus_wdata[ID_LSB +: 4];
            end
            if (rd_take) begin
                bus_rdata <= rd_val;
            end
        end
    end

    assign bus_rvalid = (state_q == BUS_RESP);

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
    import irq_rf_pkg::*;
#(
    parameter int unsigned N_ENT = 24,
    parameter int unsigned AW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [AW-1:0]        bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 bus_err,
    input  logic [N_ENT-1:0]     rirr_set,
    input  logic [N_ENT-1:0]     rirr_clr,
    input  logic [N_ENT-1:0]     dstat_set,
    input  logic [N_ENT-1:0]     dstat_clr,
    output logic [64*N_ENT-1:0]  ent_data,
    output logic [N_ENT-1:0]     ent_upd
);

    localparam int unsigned EIW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [31:0]    sel_q;
    win_kind_e      kind;
    logic [EIW-1:0] ent_idx;
    logic           tbl_wr_lo, tbl_wr_hi;
    logic [63:0]    ent_q [N_ENT];
    logic [63:0]    pick;
    logic [31:0]    tbl_word;

    irq_rf_decode #(.N_ENT(N_ENT), .EIW(EIW)) u_dec (
        .win_idx (sel_q[7:0]),
        .kind    (kind),
        .ent_idx (ent_idx)
    );

    irq_rf_busctl #(.AW(AW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .kind       (kind),
        .tbl_word   (tbl_word),
        .sel_q      (sel_q),
        .tbl_wr_lo  (tbl_wr_lo),
        .tbl_wr_hi  (tbl_wr_hi),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic hit;
        assign hit = (ent_idx == EIW'(i));
        irq_rf_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (tbl_wr_lo && hit),
            .wr_hi     (tbl_wr_hi && hit),
            .wdata     (bus_wdata),
            .rirr_set  (rirr_set[i]),
            .rirr_clr  (rirr_clr[i]),
            .dstat_set (dstat_set[i]),
            .dstat_clr (dstat_clr[i]),
            .q         (ent_q[i]),
            .upd       (ent_upd[i])
        );
        assign ent_data[64*i +: 64] = ent_q[i];
    end

    always_comb begin
        pick = 64'h0;
        for (int i = 0; i < N_ENT; i++) begin
            if (ent_idx == EIW'(i)) begin
                pick = ent_q[i];
            end
        end
        tbl_word = (kind == WK_HI) ? pick[63:32] : pick[31:0];
    end

endmodule

// File: rtl/irq_rf_checker.sv
module irq_rf_checker #(
    parameter int unsigned N_ENT = 24,
    parameter int unsigned AW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [AW-1:0]       bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         sel_q,
    input logic                bus_rvalid,
    input logic                bus_err,
    input logic [N_ENT-1:0]    rirr_set,
    input logic [N_ENT-1:0]    rirr_clr,
    input logic [N_ENT-1:0]    dstat_set,
    input logic [N_ENT-1:0]    dstat_clr,
    input logic [64*N_ENT-1:0] ent_data,
    input logic [N_ENT-1:0]    ent_upd
);

    logic win_wr;
    assign win_wr = bus_wr && (bus_addr == AW'(8'h10));

    AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd)); // R2

    AST_SINGLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_upd)); // R12

    AST_VERSION_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel_q[7:0] == 8'h01 && bus_wdata != 32'h0) |=> bus_err); // R4

    AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h00)) |=> (sel_q == $past(bus_wdata))); // R1

    for (genvar i = 0; i < N_ENT; i++) begin : g_chk
        logic quiet;
        assign quiet = !(rirr_set[i] || rirr_clr[i] || dstat_set[i] || dstat_clr[i]);

        AST_STATUS_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
            (win_wr && sel_q[7:0] == 8'(16 + 2 * i) && quiet) |=>
            (ent_data[64*i+14] == $past(ent_data[64*i+14]) &&
             ent_data[64*i+12] == $past(ent_data[64*i+12]))); // R7

        AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (win_wr && sel_q[7:0] == 8'(17 + 2 * i) && quiet) |=>
            $stable(ent_data[64*i +: 32])); // R8

        AST_RIRR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_set[i] |=> ent_data[64*i+14]); // R11
    end

endmodule

bind irq_redir_regfile irq_rf_checker #(.N_ENT(N_ENT), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .sel_q      (sel_q),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .rirr_set   (rirr_set),
    .rirr_clr   (rirr_clr),
    .dstat_set  (dstat_set),
    .dstat_clr  (dstat_clr),
    .ent_data   (ent_data),
    .ent_upd    (ent_upd)
);

// File: tb/sim_irq_redir_regfile.sv
module sim_irq_redir_regfile;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = 8'h0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, bus_err;
    logic [N-1:0]  rirr_set = '0, rirr_clr = '0, dstat_set = '0, dstat_clr = '0;
    logic [64*N-1:0] ent_data;
    logic [N-1:0]  ent_upd;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        last_err;
    logic [N-1:0] last_upd;

    always #10 clk = ~clk;

    irq_redir_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .rirr_set(rirr_set),
        .rirr_clr(rirr_clr), .dstat_set(dstat_set), .dstat_clr(dstat_clr),
        .ent_data(ent_data), .ent_upd(ent_upd)
    );

    function automatic logic [63:0] ent(input int i);
        return ent_data[64*i +: 64];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_side(input logic [7:0] off, input logic [31:0] d,
                           input logic [N-1:0] rs, input logic [N-1:0] rc,
                           input logic [N-1:0] ds, input logic [N-1:0] dc);
        @(negedge clk);
        bus_addr = off; bus_wdata = d; bus_wr = 1'b1;
        rirr_set = rs; rirr_clr = rc; dstat_set = ds; dstat_clr = dc;
        @(negedge clk);
        bus_wr = 1'b0; rirr_set = '0; rirr_clr = '0; dstat_set = '0; dstat_clr = '0;
        last_err = bus_err; last_upd = ent_upd;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        wr_side(off, d, '0, '0, '0, '0);
    endtask

    task automatic side(input logic [N-1:0] rs, input logic [N-1:0] rc,
                        input logic [N-1:0] ds, input logic [N-1:0] dc);
        @(negedge clk);
        rirr_set = rs; rirr_clr = rc; dstat_set = ds; dstat_clr = dc;
        @(negedge clk);
        rirr_set = '0; rirr_clr = '0; dstat_set = '0; dstat_clr = '0;
    endtask

    // driver: request a read and push the expected word for the monitor
    task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = off; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        last_err = bus_err;
    endtask

    // monitor: pop and compare when read data is valid (R2)
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [64*N-1:0] snap;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state: R9, R1
        for (int i = 0; i < N; i++) chk("R9 reset entry", ent(i), 64'h0000_0000_0001_0000);
        chk("R12 reset upd", 64'(ent_upd), 64'h0);
        rd(8'h00, 32'h0, "R1 select reset");

        // select register: R1
        wr(8'h00, 32'h0000_02A5);
        rd(8'h00, 32'h0000_02A5, "R1 select readback");

        // ID register: R3, arbitration: R5
        wr(8'h00, 32'h0);
        rd(8'h10, 32'h0, "R3 id reset");
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R3 id write err", 64'(last_err), 64'h0);
        rd(8'h10, 32'h0F00_0000, "R3 id masked");
        wr(8'h00, 32'h2);
        rd(8'h10, 32'h0F00_0000, "R5 arb mirrors id");
        wr(8'h10, 32'h0500_0000);
        chk("R5 arb write err", 64'(last_err), 64'h1);
        rd(8'h10, 32'h0F00_0000, "R5 arb unchanged");

        // version: R4
        wr(8'h00, 32'h1);
        rd(8'h10, 32'h0017_0011, "R4 version");
        wr(8'h10, 32'h0);
        chk("R4 zero write no err", 64'(last_err), 64'h0);
        wr(8'h10, 32'h7);
        chk("R4 nonzero write err", 64'(last_err), 64'h1);
        @(negedge clk);
        chk("R4 err one cycle", 64'(bus_err), 64'h0);
        rd(8'h10, 32'h0017_0011, "R4 version kept");

        // entry 0 low: R7, R12
        wr(8'h00, 32'h10);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R12 upd entry0", 64'(last_upd), 64'h1);
        chk("R7 low masked", ent(0), 64'h0000_0000_FFFF_AFFF);
        @(negedge clk);
        chk("R12 upd one cycle", 64'(ent_upd), 64'h0);
        rd(8'h10, 32'hFFFF_AFFF, "R7 low readback");

        // side strobes: R11
        side(24'h1, '0, '0, '0);
        chk("R11 rirr set", ent(0), 64'h0000_0000_FFFF_EFFF);
        side('0, '0, 24'h1, 24'h1);
        chk("R11 set beats clear", ent(0), 64'h0000_0000_FFFF_FFFF);
        wr_side(8'h10, 32'h0, '0, 24'h1, '0, '0);
        chk("R11 strobe beats bus write", ent(0), 64'h0000_0000_0000_1000);
        rd(8'h10, 32'h0000_1000, "R7 status kept readback");
        side('0, '0, '0, 24'h1);
        chk("R11 dstat clear", ent(0), 64'h0);

        // high half of last entry: R6, R8, R12
        wr(8'h00, 32'h3F);
        wr(8'h10, 32'hDEAD_BEEF);
        chk("R12 upd entry23", 64'(last_upd), 64'h80_0000);
        chk("R8 high write", ent(23), 64'hDEAD_BEEF_0001_0000);
        rd(8'h10, 32'hDEAD_BEEF, "R8 high readback");

        // entry 14 low: R6, R7
        wr(8'h00, 32'h2C);
        wr(8'h10, 32'h1234_5678);
        chk("R6 entry14", ent(14), 64'h0000_0000_1234_0678);
        chk("R6 entry13 untouched", ent(13), 64'h0000_0000_0001_0000);
        chk("R6 entry15 untouched", ent(15), 64'h0000_0000_0001_0000);

        // invalid window indices: R10
        wr(8'h00, 32'h40);
        rd(8'h10, 32'h0, "R10 invalid read zero");
        chk("R10 invalid read err", 64'(last_err), 64'h1);
        snap = ent_data;
        wr(8'h00, 32'h05);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R10 invalid write err", 64'(last_err), 64'h1);
        chk("R10 invalid write no change", 64'(ent_data == snap), 64'h1);
        chk("R10 invalid write no upd", 64'(last_upd), 64'h0);

        // bad bus offsets: R1
        wr(8'h04, 32'h0000_0033);
        rd(8'h00, 32'h0000_0005, "R1 bad offset write ignored");
        held = bus_rdata;
        @(negedge clk);
        bus_addr = 8'h08; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R1 bad offset no rvalid", 64'(bus_rvalid), 64'h0);
        chk("R1 bad offset rdata held", 64'(bus_rdata), 64'(held));

        repeat (3) @(negedge clk);
        chk("R2 all reads answered", 64'(exp_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule